// File: doc/BRIEF.md
# Modem Control and Status Tracker

This block keeps the modem-control byte of a serial port and turns it into the four active-low handshake outputs (data terminal ready, request to send and two auxiliary outputs). It also watches the four active-low handshake inputs: clear to send, data set ready, ring indicator and carrier detect. Each input passes through a two-flop synchronizer. The block then reports a status byte that holds the asserted level of each line and a sticky change flag for each line.

The host writes the control byte through a write strobe. It reads the status byte through a read strobe. The read returns the status of that cycle, and the same clock edge clears the change flags. The ring flag differs from the others: it records only the end of a ring, which is the ring pin going from low to high. A loopback bit feeds the control bits back into the status path in place of the external pins. Entering or leaving loopback is therefore reported like any other line change.

Top module: `modem_ctl_tracker`

## Requirements
- R1: The control byte resets to 0x00. A write stores write-data bits 4:0 on the next clock edge. Control bits 7:5 always read 0, whatever value was written to them. Without a write the byte holds its value.
- R2: Each output pin is low while its control bit is 1 and high otherwise: bit 0 drives `dtr_n_o`, bit 1 drives `rts_n_o`, bit 2 drives `out1_n_o` and bit 3 drives `out2_n_o`. After reset all four pins are high.
- R3: Status bits 7, 6, 5 and 4 show carrier detect, ring, data set ready and clear to send as asserted levels, where 1 means the pin is low. A pin change applied before clock edge k is visible after edge k+2 and not before.
- R4: Status bits 3, 1 and 0 are the change flags for carrier detect, data set ready and clear to send. A flag sets on any level change of its line. It stays set through later changes until a read clears it.
- R5: Status bit 2 sets only when the ring level goes from asserted to deasserted, that is, when the ring pin goes from low to high. Assertion of ring does not set it.
- R6: While the read strobe is high, the status output shows the pre-clear flags. All change flags clear at that clock edge. An event that lands on the same edge sets its flag again.
- R7: With control bit 4 set, the status levels come from the control bits: clear to send from bit 1, data set ready from bit 0, ring from bit 2 and carrier detect from bit 3. A control write shows in the status one edge after the control update. The external pins have no effect while loopback is on.
- R8: Entering or leaving loopback sets the change flags of every line whose level differs between the two sources. The ring flag follows the R5 rule.
- R9: The output pins keep following control bits 3:0 while loopback is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_rdata | output | 8 | Current control byte |
| sts_rd | input | 1 | Status read strobe; clears the change flags |
| sts_rdata | output | 8 | Status byte: levels in 7:4, change flags in 3:0 |
| cts_n_i | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n_i | input | 1 | Data-set-ready pin, active low, asynchronous |
| ri_n_i | input | 1 | Ring-indicator pin, active low, asynchronous |
| dcd_n_i | input | 1 | Carrier-detect pin, active low, asynchronous |
| dtr_n_o | output | 1 | Data-terminal-ready pin, active low |
| rts_n_o | output | 1 | Request-to-send pin, active low |
| out1_n_o | output | 1 | Auxiliary output 1, active low |
| out2_n_o | output | 1 | Auxiliary output 2, active low |

## Verification
A host read that clears the change flags can fall on the same clock edge as a new line event that sets one. The bench sets one flag on one line. It then toggles a second pin exactly two edges before it raises the read strobe, so the synchronized change reaches the flag register on the very edge that clears it. The check passes when three things hold. The read returns only the older flag. After that edge the older flag is clear. The new flag is set.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

    localparam int LINE_W = 4;

    // Bit order matches the status byte: levels in [7:4], flags in [3:0].
    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } mdm_lines_t;

    localparam int unsigned CB_DTR  = 0;
    localparam int unsigned CB_RTS  = 1;
    localparam int unsigned CB_OUT1 = 2;
    localparam int unsigned CB_OUT2 = 3;
    localparam int unsigned CB_LOOP = 4;

    localparam logic [7:0] CTL_WR_MASK = 8'h1F;

endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int              WIDTH   = 4,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stg;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.stg[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.stg[i] = st_q.stg[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.stg <= {STAGES{RST_VAL}};
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.stg[STAGES-1];

endmodule

// File: rtl/mdm_delta.sv
module mdm_delta
    import mdm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  mdm_lines_t lvl_i,
    input  logic       clr_i,
    output mdm_lines_t lvl_o,
    output mdm_lines_t delta_o
);

    typedef struct packed {
        mdm_lines_t lvl;
        mdm_lines_t delta;
    } delta_st_t;

    delta_st_t  st_d, st_q;
    mdm_lines_t ev;

    always_comb begin
        // Any toggle counts for three lines; ring counts only its trailing edge.
        ev.cts = lvl_i.cts ^ st_q.lvl.cts;
        ev.dsr = lvl_i.dsr ^ st_q.lvl.dsr;
        ev.dcd = lvl_i.dcd ^ st_q.lvl.dcd;
        ev.ri  = st_q.lvl.ri & ~lvl_i.ri;

        st_d.lvl   = lvl_i;
        // Set wins over clear so a same-edge event is not lost.
        st_d.delta = (clr_i ? mdm_lines_t'('0) : st_q.delta) | ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_o   = st_q.lvl;
    assign delta_o = st_q.delta;

endmodule

// File: rtl/modem_ctl_tracker.sv
module modem_ctl_tracker
    import mdm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic [7:0] ctl_wdata,
    output logic [7:0] ctl_rdata,
    input  logic       sts_rd,
    output logic [7:0] sts_rdata,
    input  logic       cts_n_i,
    input  logic       dsr_n_i,
    input  logic       ri_n_i,
    input  logic       dcd_n_i,
    output logic       dtr_n_o,
    output logic       rts_n_o,
    output logic       out1_n_o,
    output logic       out2_n_o
);

    localparam int STS_W = 2 * LINE_W;

    typedef struct packed {
        logic [7:0] ctl;
    } top_st_t;

    top_st_t    st_d, st_q;
    mdm_lines_t pin_raw;
    mdm_lines_t pin_sync;
    mdm_lines_t ext_lvl;
    mdm_lines_t loop_lvl;
    mdm_lines_t sel_lvl;
    mdm_lines_t cur_lvl;
    mdm_lines_t cur_delta;

    always_comb begin
        st_d = st_q;
        if (ctl_wr) begin
            st_d.ctl = ctl_wdata & CTL_WR_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_raw.dcd = dcd_n_i;
    assign pin_raw.ri  = ri_n_i;
    assign pin_raw.dsr = dsr_n_i;
    assign pin_raw.cts = cts_n_i;

    mdm_sync #(
        .WIDTH  (LINE_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL({LINE_W{1'b1}})
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(pin_raw),
        .sync_o (pin_sync)
    );

    always_comb begin
        ext_lvl      = ~pin_sync;
        loop_lvl.cts = st_q.ctl[CB_RTS];
        loop_lvl.dsr = st_q.ctl[CB_DTR];
        loop_lvl.ri  = st_q.ctl[CB_OUT1];
        loop_lvl.dcd = st_q.ctl[CB_OUT2];
        sel_lvl      = st_q.ctl[CB_LOOP] ? loop_lvl : ext_lvl;
    end

    mdm_delta u_delta (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (sel_lvl),
        .clr_i  (sts_rd),
        .lvl_o  (cur_lvl),
        .delta_o(cur_delta)
    );

    assign sts_rdata = STS_W'({cur_lvl, cur_delta});
    assign ctl_rdata = st_q.ctl;

    assign dtr_n_o  = ~st_q.ctl[CB_DTR];
    assign rts_n_o  = ~st_q.ctl[CB_RTS];
    assign out1_n_o = ~st_q.ctl[CB_OUT1];
    assign out2_n_o = ~st_q.ctl[CB_OUT2];

endmodule

// File: rtl/mdm_chk.sv
module mdm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_wr,
    input logic [4:0] ctl_wdata_lo,
    input logic [7:0] ctl_rdata,
    input logic       sts_rd,
    input logic [7:0] sts_rdata,
    input logic       dtr_n_o,
    input logic       rts_n_o,
    input logic       out1_n_o,
    input logic       out2_n_o
);

    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[7:5] == 3'b000);

    a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> ctl_rdata == {3'b000, $past(ctl_wdata_lo)});

    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> $stable(ctl_rdata));

    a_r2_pins_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> ({out2_n_o, out1_n_o, rts_n_o, dtr_n_o} == ~$past(ctl_wdata_lo[3:0])));

    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !sts_rd |=> ((sts_rdata[3:0] & $past(sts_rdata[3:0])) == $past(sts_rdata[3:0])));

    a_r4_dcts_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_rdata[0]) |-> !$stable(sts_rdata[4]));

    a_r4_ddcd_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_rdata[3]) |-> !$stable(sts_rdata[7]));

    a_r5_ring_trailing: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_rdata[2]) |-> $fell(sts_rdata[6]));

    a_r5_no_ring_lead: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_rdata[6]) |-> !$rose(sts_rdata[2]));

    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        sts_rd |=> (!$stable(sts_rdata[7:4]) || sts_rdata[3:0] == 4'h0));

    a_r7_loop_levels: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl_rdata[4]) |-> sts_rdata[7:4] ==
            {$past(ctl_rdata[3]), $past(ctl_rdata[2]), $past(ctl_rdata[0]), $past(ctl_rdata[1])});

endmodule

bind modem_ctl_tracker mdm_chk u_mdm_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_wr      (ctl_wr),
    .ctl_wdata_lo(ctl_wdata[4:0]),
    .ctl_rdata   (ctl_rdata),
    .sts_rd      (sts_rd),
    .sts_rdata   (sts_rdata),
    .dtr_n_o     (dtr_n_o),
    .rts_n_o     (rts_n_o),
    .out1_n_o    (out1_n_o),
    .out2_n_o    (out2_n_o)
);

// File: tb/modem_ctl_tracker_tb_top.sv
`timescale 1ns/1ps
module modem_ctl_tracker_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic [7:0] ctl_rdata;
    logic       sts_rd = 1'b0;
    logic [7:0] sts_rdata;
    logic       cts_n_i = 1'b1;
    logic       dsr_n_i = 1'b1;
    logic       ri_n_i = 1'b1;
    logic       dcd_n_i = 1'b1;
    logic       dtr_n_o, rts_n_o, out1_n_o, out2_n_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    modem_ctl_tracker dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (ctl_wr),
        .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata),
        .sts_rd   (sts_rd),
        .sts_rdata(sts_rdata),
        .cts_n_i  (cts_n_i),
        .dsr_n_i  (dsr_n_i),
        .ri_n_i   (ri_n_i),
        .dcd_n_i  (dcd_n_i),
        .dtr_n_o  (dtr_n_o),
        .rts_n_o  (rts_n_o),
        .out1_n_o (out1_n_o),
        .out2_n_o (out2_n_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pins();
        return {4'h0, out2_n_o, out1_n_o, rts_n_o, dtr_n_o};
    endfunction

    task automatic wr_ctl(input logic [7:0] v);
        ctl_wr    = 1'b1;
        ctl_wdata = v;
        tick(1);
        ctl_wr    = 1'b0;
    endtask

    task automatic rd_sts(output logic [7:0] v);
        sts_rd = 1'b1;
        #1 v = sts_rdata;
        tick(1);
        sts_rd = 1'b0;
    endtask

    task automatic t_reset_state();
        chk("R1 reset control", ctl_rdata, 8'h00);
        chk("R2 reset pins", pins(), 8'h0F);
        chk("R3 reset status", sts_rdata, 8'h00);
    endtask

    task automatic t_ctl_write();
        wr_ctl(8'hE5);
        chk("R1 reserved bits dropped", ctl_rdata, 8'h05);
        chk("R2 pins for 0x05", pins(), 8'h0A);
        wr_ctl(8'h0A);
        chk("R1 write 0x0A", ctl_rdata, 8'h0A);
        chk("R2 pins for 0x0A", pins(), 8'h05);
        tick(2);
        chk("R1 hold without write", ctl_rdata, 8'h0A);
        chk("R7 no loop, status untouched", sts_rdata, 8'h00);
        wr_ctl(8'h00);
        chk("R2 pins released", pins(), 8'h0F);
    endtask

    task automatic t_level_latency();
        logic [7:0] v;
        cts_n_i = 1'b0;
        tick(2);
        chk("R3 cts not yet visible", sts_rdata, 8'h00);
        tick(1);
        chk("R3 cts level and flag", sts_rdata, 8'h11);
        rd_sts(v);
        chk("R6 read returns pre-clear", v, 8'h11);
        chk("R6 flag cleared", sts_rdata, 8'h10);
        cts_n_i = 1'b1;
        tick(3);
        chk("R4 cts release flag", sts_rdata, 8'h01);
        rd_sts(v);
        chk("R6 cleared again", sts_rdata, 8'h00);
    endtask

    task automatic t_delta_sticky();
        logic [7:0] v;
        dsr_n_i = 1'b0;
        tick(3);
        dsr_n_i = 1'b1;
        tick(3);
        chk("R4 dsr flag sticky over two toggles", sts_rdata, 8'h02);
        dcd_n_i = 1'b0;
        tick(3);
        chk("R4 dcd flag plus dsr kept", sts_rdata, 8'h8A);
        rd_sts(v);
        chk("R4 read clears both", sts_rdata, 8'h80);
        dcd_n_i = 1'b1;
        tick(3);
        chk("R4 dcd release flag", sts_rdata, 8'h08);
        rd_sts(v);
    endtask

    task automatic t_ring_trailing();
        logic [7:0] v;
        ri_n_i = 1'b0;
        tick(3);
        chk("R5 ring assert sets no flag", sts_rdata, 8'h40);
        ri_n_i = 1'b1;
        tick(3);
        chk("R5 ring trailing edge flag", sts_rdata, 8'h04);
        rd_sts(v);
        chk("R5 ring flag cleared", sts_rdata, 8'h00);
    endtask

    task automatic t_read_collision();
        logic [7:0] v;
        dsr_n_i = 1'b0;
        tick(3);
        chk("R6 setup dsr", sts_rdata, 8'h22);
        cts_n_i = 1'b0;
        tick(2);
        rd_sts(v);
        chk("R6 collision read value", v, 8'h22);
        chk("R6 collision new flag kept", sts_rdata, 8'h31);
        dsr_n_i = 1'b1;
        cts_n_i = 1'b1;
        tick(3);
        rd_sts(v);
        chk("R6 idle after cleanup", sts_rdata, 8'h00);
    endtask

    task automatic t_loopback();
        logic [7:0] v;
        wr_ctl(8'h1F);
        tick(1);
        chk("R8 entering loopback flags", sts_rdata, 8'hFB);
        chk("R9 pins follow control in loop", pins(), 8'h00);
        rd_sts(v);
        cts_n_i = 1'b0;
        dcd_n_i = 1'b0;
        tick(4);
        chk("R7 external pins ignored", sts_rdata, 8'hF0);
        cts_n_i = 1'b1;
        dcd_n_i = 1'b1;
        tick(3);
        wr_ctl(8'h15);
        tick(1);
        chk("R7 loop mapping 0x15", sts_rdata, 8'h69);
        chk("R9 pins for 0x15", pins(), 8'h0A);
        rd_sts(v);
        wr_ctl(8'h05);
        tick(1);
        chk("R8 leaving loopback flags", sts_rdata, 8'h06);
        rd_sts(v);
        wr_ctl(8'h00);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset_state();
        t_ctl_write();
        t_level_latency();
        t_delta_sticky();
        t_ring_trailing();
        t_read_collision();
        t_loopback();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule